// File: doc/BRIEF.md
# Disk Controller Host Register Interface

This block is the processor side of a floppy disk controller. A host reaches it over an 8-bit data bus with active-low chip select, read and write strobes and a 2-bit register address. Inside sit the command, track, sector and data registers and a status view. The data register also passes bytes to and from the disk-side serial shifter, which shows up here only as a byte-ready strobe on reads and a byte-needed strobe on writes.

The block raises a data request when the data register needs service. It flags lost data when the host falls behind: on an overrun while reading, and on an underrun while writing, when a zero byte goes to the disk in place of the missing one. It raises an interrupt when a command finishes or a forced interrupt is signalled. The host strobes are asynchronous and pass through a synchronizer, and each access acts exactly once. The bus is split into an input, an output and an output enable, and the tri-state pad sits outside the block.

Top module: `fdc_host_regs`

## Requirements
- R1: Address 0 reads status and writes the command register. Addresses 1, 2 and 3 read and write the track, sector and data registers.
- R2: `bus_oe` is high only while `cs_n` and `rd_n` are both low. Register writes happen only for accesses with `cs_n` and `wr_n` both low.
- R3: In a read transfer (`xfer_active`=1, `mode_write`=0), a `disk_byte_valid` pulse loads `disk_byte` into the data register and sets `drq`. A host read of address 3 clears `drq`.
- R4: In a read transfer, a byte arriving while `drq` is still set sets the lost flag. The lost flag is status bit 2 and stays set until the next command write.
- R5: In a write transfer (`xfer_active`=1, `mode_write`=1), a `disk_byte_req` pulse with `drq` clear copies the data register to `disk_wbyte` and sets `drq`. A host write of address 3 clears `drq`.
- R6: In a write transfer, a `disk_byte_req` while `drq` is still set drives `disk_wbyte` to 0x00 and sets the lost flag.
- R7: The status byte is `ext_status` with bit 2 replaced by the lost flag. Bit 1 shows `drq` while `xfer_active` is 1, and shows `ext_status[1]` otherwise.
- R8: `irq` is set by `cmd_done` or `force_irq`. A status read or a command write clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: A command write loads `cmd_reg`, pulses `cmd_strobe` for one cycle, and clears `drq` and the lost flag.
- R10: An access takes effect on the third rising clock edge after its strobe goes active, and acts only once however long the strobe is held.
- R11: While `xfer_active` is 0, `disk_byte_valid` and `disk_byte_req` have no effect on the data register, `drq`, the lost flag or `disk_wbyte`.
- R12: If a disk event and a host data access take effect on the same edge, the host access counts as in time. On a read, the new byte is loaded, `drq` stays set and no loss is flagged. On a write, the host byte goes straight to `disk_wbyte` and no loss is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address |
| bus_in | input | 8 | Data from host |
| bus_out | output | 8 | Data to host |
| bus_oe | output | 1 | Output enable for the bus pad |
| mode_write | input | 1 | 1 = write transfer, 0 = read transfer |
| xfer_active | input | 1 | Data transfer in progress |
| disk_byte | input | 8 | Assembled byte from the disk shifter |
| disk_byte_valid | input | 1 | Pulse: an assembled byte is ready |
| disk_byte_req | input | 1 | Pulse: the shifter needs the next byte |
| disk_wbyte | output | 8 | Byte handed to the disk shifter |
| ext_status | input | 8 | Status bits from the command engine |
| cmd_done | input | 1 | Pulse: the command completed |
| force_irq | input | 1 | Pulse: a forced interrupt condition was met |
| cmd_reg | output | 8 | Last command written |
| track_reg | output | 8 | Track register |
| sector_reg | output | 8 | Sector register |
| cmd_strobe | output | 1 | One-cycle pulse on a command write |
| drq | output | 1 | Data request |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge here. A disk byte event can coincide with the host's data-register access, and a command completion can coincide with the status read that clears the interrupt. Because a host access takes effect on a fixed edge, the bench can raise the disk strobe, or `cmd_done`, in exactly the cycle the synchronized access takes effect. It then checks three things: the byte that results, `drq` and the lost bit read back through status, and whether `irq` is still set.

// File: rtl/fdc_host_regs.sv
module fdc_host_regs #(
  parameter int DW = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic          mode_write,
  input  logic          xfer_active,
  input  logic [DW-1:0] disk_byte,
  input  logic          disk_byte_valid,
  input  logic          disk_byte_req,
  output logic [DW-1:0] disk_wbyte,
  input  logic [DW-1:0] ext_status,
  input  logic          cmd_done,
  input  logic          force_irq,
  output logic [DW-1:0] cmd_reg,
  output logic [DW-1:0] track_reg,
  output logic [DW-1:0] sector_reg,
  output logic          cmd_strobe,
  output logic          drq,
  output logic          irq
);
  localparam logic [1:0] A_CMD = 2'd0, A_TRK = 2'd1, A_SEC = 2'd2, A_DAT = 2'd3;

  logic [SYNC:0] rd_sh, wr_sh;
  logic [DW-1:0] data_q, stat;
  logic          lost_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_sh <= '0;
      wr_sh <= '0;
    end else begin
      rd_sh <= {rd_sh[SYNC-1:0], ~cs_n & ~rd_n};
      wr_sh <= {wr_sh[SYNC-1:0], ~cs_n & ~wr_n};
    end

  wire rd_go  = rd_sh[SYNC-1] & ~rd_sh[SYNC];
  wire wr_go  = wr_sh[SYNC-1] & ~wr_sh[SYNC];
  wire rd_st  = rd_go && addr == A_CMD;
  wire rd_dat = rd_go && addr == A_DAT;
  wire wr_cmd = wr_go && addr == A_CMD;
  wire wr_dat = wr_go && addr == A_DAT;
  wire rx_evt = xfer_active && !mode_write && disk_byte_valid;
  wire tx_evt = xfer_active && mode_write && disk_byte_req;

  always_comb begin
    stat    = ext_status;
    stat[2] = lost_q;
    stat[1] = xfer_active ? drq : ext_status[1];
  end

  assign bus_oe = ~cs_n & ~rd_n;
  always_comb
    case (addr)
      A_CMD:   bus_out = stat;
      A_TRK:   bus_out = track_reg;
      A_SEC:   bus_out = sector_reg;
      default: bus_out = data_q;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_reg    <= '0;
      track_reg  <= '0;
      sector_reg <= '0;
      cmd_strobe <= 1'b0;
      irq        <= 1'b0;
    end else begin
      cmd_strobe <= wr_cmd;
      if (wr_cmd) cmd_reg <= bus_in;
      if (wr_go && addr == A_TRK) track_reg <= bus_in;
      if (wr_go && addr == A_SEC) sector_reg <= bus_in;
      if (cmd_done || force_irq) irq <= 1'b1;
      else if (rd_st || wr_cmd)  irq <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q     <= '0;
      disk_wbyte <= '0;
      drq        <= 1'b0;
      lost_q     <= 1'b0;
    end else if (wr_cmd) begin
      drq    <= 1'b0;
      lost_q <= 1'b0;
    end else if (rx_evt) begin
      data_q <= disk_byte;
      drq    <= 1'b1;
      if (drq && !rd_dat) lost_q <= 1'b1;
    end else if (tx_evt) begin
      drq <= 1'b1;
      if (wr_dat) begin
        data_q     <= bus_in;
        disk_wbyte <= bus_in;
      end else if (!drq) begin
        disk_wbyte <= data_q;
      end else begin
        disk_wbyte <= '0;
        lost_q     <= 1'b1;
      end
    end else begin
      if (rd_dat && !mode_write) drq <= 1'b0;
      if (wr_dat) begin
        data_q <= bus_in;
        if (mode_write) drq <= 1'b0;
      end
    end
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          bus_oe,
  input logic          drq,
  input logic          irq,
  input logic          lost_q,
  input logic          cmd_strobe,
  input logic          mode_write,
  input logic          xfer_active,
  input logic          disk_byte_valid,
  input logic          disk_byte_req,
  input logic [DW-1:0] disk_wbyte,
  input logic          cmd_done,
  input logic          force_irq
);
  p_no_drive_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || cs_n) |-> !bus_oe);

  p_drq_from_disk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> $past(xfer_active && (disk_byte_valid || disk_byte_req)));

  p_lost_from_disk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(xfer_active && (disk_byte_valid || disk_byte_req)));

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lost_q) && $past(mode_write)) |-> disk_wbyte == '0);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cmd_done || force_irq));

  p_cmd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |-> (!drq && !lost_q));

  p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  always_comb assert (!(bus_oe && !wr_n && !cs_n && rd_n));
endmodule

bind fdc_host_regs fdc_host_regs_chk #(.DW(DW)) u_chk (.*);

// File: tb/fdc_host_regs_tb.sv
`timescale 1ns/1ps
module fdc_host_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] bus_in = '0, disk_byte = '0, ext_status = '0;
  logic mode_write = 1'b0, xfer_active = 1'b0;
  logic disk_byte_valid = 1'b0, disk_byte_req = 1'b0, cmd_done = 1'b0, force_irq = 1'b0;
  logic [7:0] bus_out, disk_wbyte, cmd_reg, track_reg, sector_reg;
  logic bus_oe, cmd_strobe, drq, irq;

  int checks = 0, fails = 0, pulses = 0;
  logic oe_seen, strobe_pre, strobe_post;
  logic [7:0] got;

  always #10 clk = ~clk;

  fdc_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .mode_write(mode_write),
    .xfer_active(xfer_active), .disk_byte(disk_byte), .disk_byte_valid(disk_byte_valid),
    .disk_byte_req(disk_byte_req), .disk_wbyte(disk_wbyte), .ext_status(ext_status),
    .cmd_done(cmd_done), .force_irq(force_irq), .cmd_reg(cmd_reg), .track_reg(track_reg),
    .sector_reg(sector_reg), .cmd_strobe(cmd_strobe), .drq(drq), .irq(irq)
  );

  always @(negedge clk) if (cmd_strobe) pulses++;

  // ops: 0 host write, 1 host read, 2 disk byte in, 3 disk byte request,
  // 4 mode {xfer_active, mode_write}, 5 set ext_status, 6 cmd_done, 7 check {drq, irq}
  localparam int NV = 49;
  localparam logic [24:0] VEC [NV] = '{
    {4'd1, 3'd0, 2'd1, 8'h12, 8'h00},  // R1
    {4'd1, 3'd0, 2'd2, 8'h34, 8'h00},  // R1
    {4'd1, 3'd0, 2'd3, 8'h56, 8'h00},  // R1
    {4'd1, 3'd1, 2'd1, 8'h00, 8'h12},  // R1
    {4'd1, 3'd1, 2'd2, 8'h00, 8'h34},  // R1
    {4'd1, 3'd1, 2'd3, 8'h00, 8'h56},  // R1
    {4'd9, 3'd0, 2'd0, 8'h80, 8'h00},  // R9
    {4'd7, 3'd1, 2'd0, 8'h00, 8'h00},  // R7
    {4'd3, 3'd4, 2'd0, 8'h02, 8'h00},  // R3
    {4'd3, 3'd2, 2'd0, 8'hA1, 8'h00},  // R3
    {4'd3, 3'd7, 2'd0, 8'h02, 8'h00},  // R3
    {4'd7, 3'd1, 2'd0, 8'h00, 8'h02},  // R7
    {4'd3, 3'd1, 2'd3, 8'h00, 8'hA1},  // R3
    {4'd3, 3'd7, 2'd0, 8'h00, 8'h00},  // R3
    {4'd4, 3'd2, 2'd0, 8'hB2, 8'h00},  // R4
    {4'd4, 3'd2, 2'd0, 8'hC3, 8'h00},  // R4
    {4'd4, 3'd1, 2'd0, 8'h00, 8'h06},  // R4
    {4'd4, 3'd1, 2'd3, 8'h00, 8'hC3},  // R4
    {4'd4, 3'd1, 2'd0, 8'h00, 8'h04},  // R4
    {4'd9, 3'd0, 2'd0, 8'h10, 8'h00},  // R9
    {4'd9, 3'd1, 2'd0, 8'h00, 8'h00},  // R9
    {4'd5, 3'd4, 2'd0, 8'h03, 8'h00},  // R5
    {4'd5, 3'd0, 2'd3, 8'h5A, 8'h00},  // R5
    {4'd5, 3'd7, 2'd0, 8'h00, 8'h00},  // R5
    {4'd5, 3'd3, 2'd0, 8'h00, 8'h5A},  // R5
    {4'd5, 3'd7, 2'd0, 8'h02, 8'h00},  // R5
    {4'd6, 3'd3, 2'd0, 8'h00, 8'h00},  // R6
    {4'd6, 3'd1, 2'd0, 8'h00, 8'h06},  // R6
    {4'd5, 3'd0, 2'd3, 8'h77, 8'h00},  // R5
    {4'd6, 3'd1, 2'd0, 8'h00, 8'h04},  // R6
    {4'd5, 3'd3, 2'd0, 8'h00, 8'h77},  // R5
    {4'd9, 3'd0, 2'd0, 8'h20, 8'h00},  // R9
    {4'd9, 3'd1, 2'd0, 8'h00, 8'h00},  // R9
    {4'd11, 3'd4, 2'd0, 8'h00, 8'h00}, // R11
    {4'd11, 3'd0, 2'd3, 8'h99, 8'h00}, // R11
    {4'd11, 3'd2, 2'd0, 8'h11, 8'h00}, // R11
    {4'd11, 3'd1, 2'd3, 8'h00, 8'h99}, // R11
    {4'd11, 3'd3, 2'd0, 8'h00, 8'h77}, // R11
    {4'd11, 3'd7, 2'd0, 8'h00, 8'h00}, // R11
    {4'd7, 3'd5, 2'd0, 8'hFF, 8'h00},  // R7
    {4'd7, 3'd1, 2'd0, 8'h00, 8'hFB},  // R7
    {4'd7, 3'd5, 2'd0, 8'h00, 8'h00},  // R7
    {4'd8, 3'd6, 2'd0, 8'h00, 8'h00},  // R8
    {4'd8, 3'd7, 2'd0, 8'h01, 8'h00},  // R8
    {4'd8, 3'd1, 2'd0, 8'h00, 8'h00},  // R8
    {4'd8, 3'd7, 2'd0, 8'h00, 8'h00},  // R8
    {4'd8, 3'd6, 2'd0, 8'h00, 8'h00},  // R8
    {4'd8, 3'd0, 2'd0, 8'h30, 8'h00},  // R8
    {4'd8, 3'd7, 2'd0, 8'h00, 8'h00}   // R8
  };

  task automatic chk(input int r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %02h expected %02h", r, act, exp);
    end
  endtask

  // side: 0 none, 1 disk byte in, 2 disk byte request, 3 cmd_done; fired on the edge the access acts
  task automatic access(input bit is_rd, input logic [1:0] a, input logic [7:0] d,
                        input int side, input logic [7:0] sd, output logic [7:0] rd);
    @(negedge clk);
    addr = a; bus_in = d; cs_n = 1'b0;
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    @(negedge clk);
    rd = bus_out; oe_seen = bus_oe;
    @(negedge clk);
    strobe_pre = cmd_strobe;
    case (side)
      1: begin disk_byte = sd; disk_byte_valid = 1'b1; end
      2: disk_byte_req = 1'b1;
      3: cmd_done = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    strobe_post = cmd_strobe;
    disk_byte_valid = 1'b0; disk_byte_req = 1'b0; cmd_done = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_in(input int which, input logic [7:0] b);
    @(negedge clk);
    case (which)
      2: begin disk_byte = b; disk_byte_valid = 1'b1; end
      3: disk_byte_req = 1'b1;
      6: cmd_done = 1'b1;
      default: force_irq = 1'b1;
    endcase
    @(negedge clk);
    disk_byte_valid = 1'b0; disk_byte_req = 1'b0; cmd_done = 1'b0; force_irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 R8 reset state
    chk(9, {6'd0, drq, cmd_strobe}, 8'h00);
    chk(8, {7'd0, irq}, 8'h00);
    chk(2, {7'd0, bus_oe}, 8'h00);                 // R2 idle
    access(1'b1, 2'd0, 8'h00, 0, 8'h00, got);
    chk(7, got, 8'h00);                            // R7 status after reset
    chk(2, {7'd0, oe_seen}, 8'h01);                // R2 driven during read

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [2:0] op; logic [1:0] a; logic [7:0] d, e;
      {rq, op, a, d, e} = VEC[i];
      case (op)
        3'd0: begin
          access(1'b0, a, d, 0, 8'h00, got);
          chk(int'(rq), {7'd0, oe_seen}, 8'h00);   // no drive on writes
        end
        3'd1: begin access(1'b1, a, 8'h00, 0, 8'h00, got); chk(int'(rq), got, e); end
        3'd2: pulse_in(2, d);
        3'd3: begin pulse_in(3, 8'h00); chk(int'(rq), disk_wbyte, e); end
        3'd4: begin mode_write = d[0]; xfer_active = d[1]; @(negedge clk); end
        3'd5: begin ext_status = d; @(negedge clk); end
        3'd6: pulse_in(6, 8'h00);
        default: chk(int'(rq), {6'd0, drq, irq}, d);
      endcase
    end

    // R10: acts on third edge, once for a long strobe
    p0 = pulses;
    access(1'b0, 2'd0, 8'h41, 0, 8'h00, got);
    chk(10, {7'd0, strobe_pre}, 8'h00);
    chk(10, {7'd0, strobe_post}, 8'h01);
    chk(10, 8'(pulses - p0), 8'h01);
    chk(9, cmd_reg, 8'h41);                        // R9
    chk(1, {track_reg[3:0], sector_reg[3:0]}, 8'h24); // R1 track 0x12 sector 0x34

    // R8 forced interrupt, then same-cycle set and clear
    pulse_in(7, 8'h00);
    chk(8, {7'd0, irq}, 8'h01);
    access(1'b1, 2'd0, 8'h00, 0, 8'h00, got);
    chk(8, {7'd0, irq}, 8'h00);
    access(1'b1, 2'd0, 8'h00, 3, 8'h00, got);
    chk(8, {7'd0, irq}, 8'h01);                    // R8 set wins

    // R12 read side: byte arrives on the edge of the data read
    access(1'b0, 2'd0, 8'h50, 0, 8'h00, got);
    mode_write = 1'b0; xfer_active = 1'b1;
    pulse_in(2, 8'h44);
    access(1'b1, 2'd3, 8'h00, 1, 8'h55, got);
    chk(12, got, 8'h44);
    access(1'b1, 2'd0, 8'h00, 0, 8'h00, got);
    chk(12, got, 8'h02);
    access(1'b1, 2'd3, 8'h00, 0, 8'h00, got);
    chk(12, got, 8'h55);

    // R12 write side: host byte lands on the edge of the request
    access(1'b0, 2'd0, 8'h60, 0, 8'h00, got);
    mode_write = 1'b1;
    access(1'b0, 2'd3, 8'h66, 0, 8'h00, got);
    pulse_in(3, 8'h00);
    chk(5, disk_wbyte, 8'h66);                     // R5
    access(1'b0, 2'd3, 8'h88, 2, 8'h00, got);
    chk(12, disk_wbyte, 8'h88);
    access(1'b1, 2'd0, 8'h00, 0, 8'h00, got);
    chk(12, got, 8'h02);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule